// File: doc/BRIEF.md
# Junction Path Header Rewriter

This block sits between a router input buffer and the switch allocator in a router that uses junction-based source routing. Each flit the buffer offers is taken into a single holding stage. A head flit whose route has run out, or that has reached its junction, is held there. While it waits, the block asks a shared path table for a new route, keyed by the head's destination address. The returned route is written into the head's path field, the header flags are updated, and the head is then offered downstream. Body and end flits, and head flits that already carry a full route, pass through the same stage unchanged.

Whether a router acts as a junction is set on a static input. A head flit that marks itself for a junction is only rewritten in a router with that input high. Any other router forwards it as it is. The table may take any number of cycles to answer, because it is shared with other ports. The block keeps its request and key steady until the grant comes, and takes no further input while it waits.

Top module: `junction_hdr_mod`

## Requirements
- R1: A flit is 34 bits wide. Bits [33:32] hold the flit type, and only code 00 marks a head flit. In a head flit, bit 31 is the route-exhausted flag, bit 30 is the junction flag, bits [29:14] are the path field (eight 2-bit hops), bits [13:6] are the destination address and bits [5:0] are payload.
- R2: A head flit with bit 31 set causes a table request with `tbl_dest` equal to its bits [13:6]. On grant, the forwarded flit carries `tbl_path` in bits [29:14], bit 31 cleared and bit 30 equal to `tbl_jnc`. Every other bit is kept. The flit is offered in the cycle after the grant.
- R3: A head flit with bit 31 clear and bit 30 set is rewritten exactly as in R2 when `jnc_here` is 1.
- R4: A head flit with bit 31 clear and bit 30 set is forwarded unchanged, with no table request, when `jnc_here` is 0.
- R5: A head flit with bits 31 and 30 both clear is forwarded unchanged, with no table request.
- R6: A flit whose type is not 00 is forwarded unchanged, with no table request, whatever its bits 31 and 30 hold.
- R7: Once raised, `tbl_req` stays high with `tbl_dest` stable until a cycle with `tbl_gnt` high, for a stall of any length.
- R8: No flit is taken (`in_get` low) while a table request is pending. Flits leave in the order they were taken.
- R9: While `out_valid` is high and `out_accept` is low, `out_valid` stays high and `out_flit` stays stable.
- R10: While reset is held and after its release, `out_valid`, `tbl_req` and `in_get` are low until a flit is offered.
- R11: A flit that needs no lookup is offered on `out_valid` in the cycle after it is taken. With `out_accept` held high, one such flit moves per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| jnc_here | input | 1 | This router serves as a junction |
| in_valid | input | 1 | Input buffer offers a flit |
| in_flit | input | 34 | Offered flit |
| in_get | output | 1 | Offered flit is taken this cycle |
| tbl_req | output | 1 | Path lookup requested |
| tbl_dest | output | 8 | Lookup key (destination address) |
| tbl_gnt | input | 1 | Lookup served this cycle |
| tbl_path | input | 16 | Returned route, valid with grant |
| tbl_jnc | input | 1 | Returned route ends at another junction |
| out_valid | output | 1 | Flit offered downstream |
| out_flit | output | 34 | Offered flit |
| out_accept | input | 1 | Downstream takes the flit this cycle |

## Verification
The bench applies each flag combination to head flits with the junction strap both low and high. A design that decodes the junction flag without checking the strap would issue spurious lookups, and these are caught as requests the model does not expect. Body and end flits are sent with both flag bits set, so a design that looks at the flags without first checking the type would rewrite data. Table stalls of up to forty cycles, together with random downstream back-pressure, show whether the request is dropped, the key changes while waiting, a new flit is taken during a lookup, or a stalled output changes. A run of back-to-back pass-through flits exposes a stage that loses a cycle per flit.

// File: rtl/hm_pkg.sv
// Shared constants and types for the junction path header rewriter.
// Assumes the fixed head layout: type, flags, path, destination, payload.
package hm_pkg;
    localparam int HOP_W   = 2;
    localparam int HOPS    = 8;
    localparam int PATH_W  = HOP_W * HOPS;
    localparam int DEST_W  = 8;
    localparam int PAY_W   = 6;
    localparam int TYPE_W  = 2;
    localparam int FLIT_W  = TYPE_W + 2 + PATH_W + DEST_W + PAY_W;

    localparam int DEST_LO = PAY_W;
    localparam int PATH_LO = DEST_LO + DEST_W;
    localparam int J_POS   = PATH_LO + PATH_W;
    localparam int R_POS   = J_POS + 1;
    localparam int TYPE_LO = R_POS + 1;

    localparam logic [TYPE_W-1:0] TYPE_HEAD = '0;

    typedef enum logic [1:0] {
        HM_IDLE = 2'd0,
        HM_LOOK = 2'd1,
        HM_SEND = 2'd2
    } hm_state_e;
endpackage

// File: rtl/hm_classify.sv
// Decides whether an incoming flit needs a path table lookup.
// Assumes only type code zero marks a head; flags are ignored otherwise.
module hm_classify
    import hm_pkg::*;
(
    input  logic [TYPE_W-1:0] ftype,
    input  logic              rbit,
    input  logic              jbit,
    input  logic              jnc_here,
    output logic              need_lookup
);
    // Head flits ask the table when the route is exhausted or at their junction.
    always_comb begin
        need_lookup = (ftype == TYPE_HEAD) && (rbit || (jbit && jnc_here));
    end
endmodule

// File: rtl/hm_splice.sv
// Builds the rewritten head flit from a held flit and a table answer.
// Assumes path is valid when the caller uses the result.
module hm_splice
    import hm_pkg::*;
(
    input  logic [FLIT_W-1:0] flit_in,
    input  logic [PATH_W-1:0] path,
    input  logic              jflag,
    output logic [FLIT_W-1:0] flit_out
);
    logic [PATH_W-1:0] hop_path;

    // Place each returned hop into its slot of the path field.
    for (genvar h = 0; h < HOPS; h++) begin : g_hop
        assign hop_path[h*HOP_W +: HOP_W] = path[h*HOP_W +: HOP_W];
    end

    // Replace the path field, clear the exhausted flag, load the junction flag.
    always_comb begin
        flit_out = flit_in;
        flit_out[PATH_LO +: PATH_W] = hop_path;
        flit_out[R_POS] = 1'b0;
        flit_out[J_POS] = jflag;
    end
endmodule

// File: rtl/junction_hdr_mod.sv
// Junction path header rewriter: one holding stage between an input buffer
// and the switch allocator. Head flits needing a route wait there while the
// shared path table is queried; all other flits pass through in one cycle.
// Assumes jnc_here is static while flits are in flight.
module junction_hdr_mod
    import hm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              jnc_here,
    input  logic              in_valid,
    input  logic [FLIT_W-1:0] in_flit,
    output logic              in_get,
    output logic              tbl_req,
    output logic [DEST_W-1:0] tbl_dest,
    input  logic              tbl_gnt,
    input  logic [PATH_W-1:0] tbl_path,
    input  logic              tbl_jnc,
    output logic              out_valid,
    output logic [FLIT_W-1:0] out_flit,
    input  logic              out_accept
);
    hm_state_e         state;
    logic [FLIT_W-1:0] hold;
    logic [FLIT_W-1:0] spliced;
    logic              need_lookup;

    hm_classify u_cls (
        .ftype       (in_flit[TYPE_LO +: TYPE_W]),
        .rbit        (in_flit[R_POS]),
        .jbit        (in_flit[J_POS]),
        .jnc_here    (jnc_here),
        .need_lookup (need_lookup)
    );

    hm_splice u_spl (
        .flit_in  (hold),
        .path     (tbl_path),
        .jflag    (tbl_jnc),
        .flit_out (spliced)
    );

    // Take a flit when the stage is empty or is emptying this cycle.
    always_comb begin
        in_get = rst_n && in_valid &&
                 ((state == HM_IDLE) || ((state == HM_SEND) && out_accept));
    end

    // Drive the table and downstream interfaces from the holding stage.
    always_comb begin
        tbl_req   = (state == HM_LOOK);
        tbl_dest  = hold[DEST_LO +: DEST_W];
        out_valid = (state == HM_SEND);
        out_flit  = hold;
    end

    // Stage control: capture, wait for the table, offer downstream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HM_IDLE;
            hold  <= '0;
        end else begin
            case (state)
                HM_LOOK: begin
                    if (tbl_gnt) begin
                        hold  <= spliced;
                        state <= HM_SEND;
                    end
                end
                default: begin
                    if (in_get) begin
                        hold  <= in_flit;
                        state <= need_lookup ? HM_LOOK : HM_SEND;
                    end else if (state == HM_SEND && out_accept) begin
                        state <= HM_IDLE;
                    end
                end
            endcase
        end
    end

    // R7: request and key held through any stall.
    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_req && !tbl_gnt) |=> (tbl_req && $stable(tbl_dest)));

    // R9: stalled output holds its flit.
    a_r9_out_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_accept) |=> (out_valid && $stable(out_flit)));

    // R8: nothing is taken while a lookup is pending.
    a_r8_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_req |-> !in_get);

    // R2: granted route appears in the next offered flit with flags updated.
    a_r2_splice: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_req && tbl_gnt) |=> (out_valid && !out_flit[R_POS]
            && out_flit[PATH_LO +: PATH_W] == $past(tbl_path)
            && out_flit[J_POS] == $past(tbl_jnc)));

    // R11: a flit needing no lookup is offered unchanged next cycle.
    a_r11_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_get && !need_lookup) |=> (out_valid && out_flit == $past(in_flit)));
endmodule

// File: tb/sim_junction_hdr_mod.sv
module sim_junction_hdr_mod;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        jnc_here = 1'b0;
    logic        in_valid = 1'b0;
    logic [33:0] in_flit = '0;
    logic        in_get;
    logic        tbl_req;
    logic [7:0]  tbl_dest;
    logic        tbl_gnt = 1'b0;
    logic [15:0] tbl_path = '0;
    logic        tbl_jnc = 1'b0;
    logic        out_valid;
    logic [33:0] out_flit;
    logic        out_accept = 1'b0;

    always #5 clk = ~clk;

    junction_hdr_mod u0 (.*);

    int checks = 0;
    int failures = 0;

    logic [33:0] src [0:1023];
    logic [33:0] expq [0:1023];
    string       tagq [0:1023];
    logic [7:0]  lkq [0:1023];

    task automatic chk(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Table content model: route and junction flag derived from the key.
    function automatic logic [16:0] tbl_fn(input logic [7:0] d);
        return {^d, d ^ 8'h5A, ~d};
    endfunction

    function automatic bit needs_lk(input logic [33:0] f, input logic here);
        return (f[33:32] == 2'b00) && (f[31] || (f[30] && here));
    endfunction

    function automatic logic [33:0] exp_out(input logic [33:0] f, input logic here);
        logic [33:0] r;
        logic [16:0] t;
        r = f;
        if (needs_lk(f, here)) begin
            t = tbl_fn(f[13:6]);
            r[31] = 1'b0;
            r[30] = t[16];
            r[29:14] = t[15:0];
        end
        return r;
    endfunction

    function automatic string kind(input logic [33:0] f, input logic here);
        if (f[33:32] != 2'b00) return "R6";
        if (f[31]) return "R2";
        if (f[30]) return here ? "R3" : "R4";
        return "R5";
    endfunction

    function automatic logic [33:0] mk(input logic [1:0] ty, input logic r, input logic j,
                                       input logic [7:0] d, input logic [5:0] p);
        return {ty, r, j, 16'hFFFF ^ {d, d}, d, p};
    endfunction

    // Offer src[0..n-1], model the table and downstream, check every output.
    task automatic run(input int n, input logic here, input int smin, input int smax,
                       input int apct, input int vpct, input string first_tag);
        int sent = 0, eh = 0, et = 0, lh = 0, lt = 0, cyc = 0, stall_left = 0;
        bit offering = 0, stall_set = 0, due = 0, prev_ostall = 0, prev_rstall = 0;
        logic [33:0] prev_flit = '0;
        logic [7:0]  prev_dest = '0;
        jnc_here = here;
        while (sent < n || eh != et) begin
            @(negedge clk);
            cyc++;
            if (cyc > n * 100 + 500) begin
                chk(0, "watchdog", 34'(cyc), 34'(n));
                break;
            end
            if (!offering) offering = (sent < n) && (($urandom % 100) < vpct);
            in_valid = offering;
            in_flit = offering ? src[sent] : 34'(64'($urandom) << 8);
            out_accept = (($urandom % 100) < apct);
            tbl_gnt = 1'b0;
            {tbl_jnc, tbl_path} = 17'($urandom);
            if (tbl_req) begin
                if (!stall_set) begin
                    stall_left = smin + int'($urandom % (smax - smin + 1));
                    stall_set = 1;
                end
                if (stall_left == 0) begin
                    tbl_gnt = 1'b1;
                    {tbl_jnc, tbl_path} = tbl_fn(tbl_dest);
                    stall_set = 0;
                end else stall_left--;
            end
            #1;
            if (due) chk(out_valid, "R11/R2 offer latency", 34'(out_valid), 34'd1);
            if (prev_ostall) chk(out_valid && out_flit == prev_flit, "R9 stalled output", out_flit, prev_flit);
            if (prev_rstall) chk(tbl_req && tbl_dest == prev_dest, "R7 request held", 34'(tbl_dest), 34'(prev_dest));
            if (tbl_req && in_valid) chk(!in_get, "R8 take during lookup", 34'(in_get), 34'd0);
            if (tbl_req) begin
                if (lh == lt) chk(0, "R4/R5/R6 unexpected lookup", 34'(tbl_dest), 34'd0);
                else if (tbl_gnt) begin
                    chk(tbl_dest == lkq[lh], "R2/R3 lookup key", 34'(tbl_dest), 34'(lkq[lh]));
                    lh++;
                end
            end
            if (out_valid && out_accept) begin
                if (eh == et) chk(0, "R8 extra output", out_flit, '0);
                else begin
                    chk(out_flit == expq[eh], tagq[eh], out_flit, expq[eh]);
                    eh++;
                end
            end
            due = tbl_req && tbl_gnt;
            if (in_valid && in_get) begin
                expq[et] = exp_out(in_flit, here);
                tagq[et] = (sent == 0 && first_tag != "") ? first_tag : kind(in_flit, here);
                et++;
                if (needs_lk(in_flit, here)) begin
                    lkq[lt] = in_flit[13:6];
                    lt++;
                end else due = 1;
                sent++;
                offering = 0;
            end
            prev_ostall = out_valid && !out_accept;
            prev_flit = out_flit;
            prev_rstall = tbl_req && !tbl_gnt;
            prev_dest = tbl_dest;
        end
        @(negedge clk);
        in_valid = 1'b0;
        out_accept = 1'b0;
        tbl_gnt = 1'b0;
    endtask

    initial begin : main
        int n;
        void'($urandom(32'd1234));
        in_valid = 1'b1;
        in_flit = mk(2'b01, 1'b0, 1'b0, 8'h11, 6'h2);
        repeat (3) @(negedge clk);
        chk(!out_valid && !tbl_req && !in_get, "R10 during reset", {out_valid, tbl_req, in_get}, '0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!out_valid && !tbl_req && !in_get, "R10 after reset", {out_valid, tbl_req, in_get}, '0);

        // R1: field positions; then non-head flits with flags set (R6), R4, R5.
        src[0] = mk(2'b00, 1'b1, 1'b0, 8'h3C, 6'h15);
        src[1] = mk(2'b01, 1'b1, 1'b1, 8'h77, 6'h3F);
        src[2] = mk(2'b10, 1'b1, 1'b1, 8'h81, 6'h01);
        src[3] = mk(2'b00, 1'b0, 1'b1, 8'hC3, 6'h2A);
        src[4] = mk(2'b00, 1'b0, 1'b0, 8'h05, 6'h11);
        run(5, 1'b0, 0, 3, 100, 100, "R1");

        // R3 at a junction, immediate grants.
        src[0] = mk(2'b00, 1'b0, 1'b1, 8'hA4, 6'h09);
        src[1] = mk(2'b00, 1'b1, 1'b1, 8'hFF, 6'h30);
        src[2] = mk(2'b00, 1'b0, 1'b0, 8'h00, 6'h00);
        src[3] = mk(2'b11, 1'b0, 1'b1, 8'h44, 6'h12);
        run(4, 1'b1, 0, 0, 100, 100, "");

        // R7: long table stall with downstream back-pressure.
        src[0] = mk(2'b00, 1'b1, 1'b0, 8'h5E, 6'h0C);
        src[1] = mk(2'b01, 1'b0, 1'b0, 8'h5E, 6'h0D);
        run(2, 1'b1, 40, 40, 30, 100, "");

        // Random mixes, junction strap low then high.
        for (int ph = 0; ph < 2; ph++) begin
            n = 600;
            for (int i = 0; i < n; i++) src[i] = 34'({$urandom, $urandom});
            run(n, ph[0], 0, 5, 60, 70, "");
        end

        // R11: back-to-back pass-through flits, one per cycle.
        for (int i = 0; i < 50; i++) src[i] = mk(2'b01, i[0], i[1], 8'(i), 6'(i));
        run(50, 1'b0, 0, 0, 100, 100, "R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog global timeout actual=%0d expected=0", 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule